// File: doc/BRIEF.md
# Character LCD Command Sequencer

This block sits in front of a 24-bit serial frame transmitter that talks to a character/graphics LCD controller. After system reset it pulses the display's hardware reset line low. It waits for the controller to wake up, then plays a fixed start-up script. The script has one dummy data write of 0x00, which puts the serial path into a known idle state. It then sends a display-clear command and four basic set-up commands.

Once the script has finished, the block accepts byte requests from a user port through a valid/ready handshake. Each request carries a flag that marks it as a command or as display data. For every byte, the block first presents it to the transmitter in a load phase with the matching register-select level. It then raises run until the transmitter reports done. It then waits for a hold-off time that depends on what was sent, so the controller can finish executing it before the next byte arrives.

All waits are derived from a clock-frequency parameter given in kHz. Each wait is rounded up to whole cycles, with a minimum of one cycle.

States:
- `SQ_RST_LOW`: reset line driven low.
- `SQ_RST_WAIT`: reset line released, waiting for the controller.
- `SQ_LOAD`: byte and register select presented with load high.
- `SQ_RUN`: run high until done.
- `SQ_HOLD`: execution hold-off.
- `SQ_IDLE`: ready for user traffic.

Transitions:
- reset-low timeout goes to reset-wait.
- reset-wait timeout goes to load, with script entry 0.
- load timeout goes to run.
- done goes from run to hold.
- hold timeout goes to load when script entries remain, otherwise to idle.
- an accepted request goes from idle to load.

Top module: `lcd_cmd_sequencer`

## Requirements
- R1: `lcd_rst_n` is low while `rst_n` is low and for the reset-low time (100 ms worth of cycles, counting the cycle in which `rst_n` releases). After that it is high and stays high.
- R2: After a further 200 ms with the reset line high, the first transfer is a data write of 0x00, and the second is the display-clear command 0x01.
- R3: `tx_rs` is 0 for a command byte and 1 for a data byte. `tx_byte` carries the byte throughout the load and run phases of its transfer.
- R4: After a display-clear command (command 0x01), exactly 1600 us worth of cycles pass with load, run and ready all low before the next load or ready.
- R5: After any other command the hold-off is 200 us worth of cycles. After a data byte it is 50 us worth of cycles.
- R6: After the clear, the script sends the commands 0x06, 0x0E, 0x14 and 0x20 in that order. `req_ready` stays low until the last of them has completed its hold-off.
- R7: `tx_load` is high for exactly `LOAD_CYCLES` cycles with `tx_byte`/`tx_rs` stable. `tx_run` follows immediately, and load and run are never high together.
- R8: `tx_run` stays high until the cycle in which `tx_done` is seen and drops on the next cycle. The hold-off starts only after done.
- R9: `req_ready` is high only in idle. A request with `req_valid` high while ready is high is sent next, and ready drops on the next cycle. `req_valid` while ready is low is ignored: no transfer carries that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | User request valid |
| req_is_data | input | 1 | 1 = data byte, 0 = command byte |
| req_byte | input | 8 | Byte to send |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| lcd_rst_n | output | 1 | Display hardware reset, active low |
| tx_load | output | 1 | Load phase toward transmitter |
| tx_run | output | 1 | Run phase toward transmitter |
| tx_rs | output | 1 | Register select for current byte |
| tx_byte | output | 8 | Current byte |
| tx_done | input | 1 | Transmitter finished the frame |

## Verification
The assertions check the following on every cycle:
- load and run are mutually exclusive;
- the byte is stable while load is held;
- run persists until done and falls right after it;
- the reset line never returns low;
- an accepted request starts a load at once.

Some behaviours only the bench's scenarios can show:
- the exact lengths of the reset and hold-off windows for each kind of byte;
- the ordering of the start-up script;
- the fact that requests raised while busy never reach the transmitter.

The bench shows these with a transmitter model whose done latency varies from one transfer to the next.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [2:0] {
        SQ_RST_LOW,
        SQ_RST_WAIT,
        SQ_LOAD,
        SQ_RUN,
        SQ_HOLD,
        SQ_IDLE
    } seq_state_t;

    // cycles for a time in microseconds at a clock given in kHz, rounded up, at least 1
    function automatic int us_to_cycles(input longint khz, input longint us);
        longint v;
        v = (khz * us + 64'd999) / 64'd1000;
        return (v < 1) ? 1 : int'(v);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/lcd_seq_timer.sv
module lcd_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt;

    // counts cycles spent in the current state; restarts on every state change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clear)  cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    assign last = (cnt == limit - 1'b1);
endmodule

// File: rtl/lcd_seq_script.sv
module lcd_seq_script (
    input  logic [2:0] idx,
    output logic [7:0] s_byte,
    output logic       s_rs,
    output logic       s_last
);
    localparam logic [2:0] LAST_IDX = 3'd5;

    always_comb begin
        unique case (idx)
            3'd0:    begin s_rs = 1'b1; s_byte = 8'h00; end  // dummy data write
            3'd1:    begin s_rs = 1'b0; s_byte = 8'h01; end  // clear
            3'd2:    begin s_rs = 1'b0; s_byte = 8'h06; end
            3'd3:    begin s_rs = 1'b0; s_byte = 8'h0E; end
            3'd4:    begin s_rs = 1'b0; s_byte = 8'h14; end
            3'd5:    begin s_rs = 1'b0; s_byte = 8'h20; end
            default: begin s_rs = 1'b0; s_byte = 8'h00; end
        endcase
    end

    assign s_last = (idx == LAST_IDX);
endmodule

// File: rtl/lcd_cmd_sequencer.sv
module lcd_cmd_sequencer
    import lcd_seq_pkg::*;
#(
    parameter int CLK_KHZ     = 50000,
    parameter int RST_LOW_US  = 100000,
    parameter int RST_WAIT_US = 200000,
    parameter int CLEAR_US    = 1600,
    parameter int CMD_US      = 200,
    parameter int DATA_US     = 50,
    parameter int LOAD_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_is_data,
    input  logic [7:0] req_byte,
    output logic       req_ready,
    output logic       lcd_rst_n,
    output logic       tx_load,
    output logic       tx_run,
    output logic       tx_rs,
    output logic [7:0] tx_byte,
    input  logic       tx_done
);
    localparam int T_RLOW  = us_to_cycles(CLK_KHZ, RST_LOW_US);
    localparam int T_RWAIT = us_to_cycles(CLK_KHZ, RST_WAIT_US);
    localparam int T_CLEAR = us_to_cycles(CLK_KHZ, CLEAR_US);
    localparam int T_CMD   = us_to_cycles(CLK_KHZ, CMD_US);
    localparam int T_DATA  = us_to_cycles(CLK_KHZ, DATA_US);
    localparam int T_LOAD  = (LOAD_CYCLES < 1) ? 1 : LOAD_CYCLES;
    localparam int T_MAX   = max2(max2(max2(T_RLOW, T_RWAIT), max2(T_CLEAR, T_CMD)),
                                  max2(T_DATA, T_LOAD));
    localparam int W       = $clog2(T_MAX + 1);
    localparam logic [7:0] CLEAR_CODE = 8'h01;

    seq_state_t   state_q, state_d;
    logic [2:0]   idx_q;
    logic         script_on_q;
    logic [7:0]   u_byte_q;
    logic         u_rs_q;
    logic [7:0]   s_byte;
    logic         s_rs, s_last;
    logic [W-1:0] limit, hold_lim;
    logic         t_last;

    lcd_seq_script u_script (
        .idx    (idx_q),
        .s_byte (s_byte),
        .s_rs   (s_rs),
        .s_last (s_last)
    );

    lcd_seq_timer #(.W(W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_d != state_q),
        .limit (limit),
        .last  (t_last)
    );

    // byte in flight: script entry during start-up, latched request afterwards
    assign tx_byte = script_on_q ? s_byte : u_byte_q;
    assign tx_rs   = script_on_q ? s_rs   : u_rs_q;

    always_comb begin
        if (tx_rs)                     hold_lim = W'(T_DATA);
        else if (tx_byte == CLEAR_CODE) hold_lim = W'(T_CLEAR);
        else                           hold_lim = W'(T_CMD);
    end

    always_comb begin
        unique case (state_q)
            SQ_RST_LOW:  limit = W'(T_RLOW);
            SQ_RST_WAIT: limit = W'(T_RWAIT);
            SQ_LOAD:     limit = W'(T_LOAD);
            SQ_HOLD:     limit = hold_lim;
            default:     limit = W'(1);
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_RST_LOW:  if (t_last)    state_d = SQ_RST_WAIT;
            SQ_RST_WAIT: if (t_last)    state_d = SQ_LOAD;
            SQ_LOAD:     if (t_last)    state_d = SQ_RUN;
            SQ_RUN:      if (tx_done)   state_d = SQ_HOLD;
            SQ_HOLD:     if (t_last)    state_d = (script_on_q && !s_last) ? SQ_LOAD : SQ_IDLE;
            SQ_IDLE:     if (req_valid) state_d = SQ_LOAD;
            default:                    state_d = SQ_RST_LOW;
        endcase
    end

    // state register and sequencing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= SQ_RST_LOW;
            idx_q       <= '0;
            script_on_q <= 1'b1;
            u_byte_q    <= '0;
            u_rs_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == SQ_HOLD && t_last && script_on_q) begin
                if (s_last) script_on_q <= 1'b0;
                else        idx_q       <= idx_q + 1'b1;
            end
            if (state_q == SQ_IDLE && req_valid) begin
                u_byte_q <= req_byte;
                u_rs_q   <= req_is_data;
            end
        end
    end

    // outputs
    always_comb begin
        lcd_rst_n = (state_q != SQ_RST_LOW);
        tx_load   = (state_q == SQ_LOAD);
        tx_run    = (state_q == SQ_RUN);
        req_ready = (state_q == SQ_IDLE);
    end

    AST_LOAD_RUN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_load && tx_run)) else $error("load and run overlap"); // R7
    AST_LOAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load && $past(tx_load) |-> $stable(tx_byte) && $stable(tx_rs)) else $error("byte moved during load"); // R7
    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_run && !tx_done |=> tx_run) else $error("run dropped early"); // R8
    AST_RUN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_run && tx_done |=> !tx_run && !tx_load) else $error("run kept after done"); // R8
    AST_RST_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_rst_n |=> lcd_rst_n) else $error("reset line reasserted"); // R1
    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> tx_load && !req_ready) else $error("accepted request not loaded"); // R9
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !tx_load && !tx_run && lcd_rst_n) else $error("ready while busy"); // R9
endmodule

// File: tb/sim_lcd_cmd_sequencer.sv
module sim_lcd_cmd_sequencer;
    // 20 kHz design clock scale: 100 ms=2000, 200 ms=4000, 1600 us=32, 200 us=4, 50 us=1 cycles
    localparam int E_RLOW = 2000, E_RWAIT = 4000, E_CLEAR = 32, E_CMD = 4, E_DATA = 1, LOADC = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_is_data = 1'b0, tx_done = 1'b0;
    logic [7:0] req_byte = 8'h00;
    logic req_ready, lcd_rst_n, tx_load, tx_run, tx_rs;
    logic [7:0] tx_byte;

    always #4 clk = ~clk;

    lcd_cmd_sequencer #(.CLK_KHZ(20), .LOAD_CYCLES(LOADC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_data(req_is_data),
        .req_byte(req_byte), .req_ready(req_ready), .lcd_rst_n(lcd_rst_n),
        .tx_load(tx_load), .tx_run(tx_run), .tx_rs(tx_rs), .tx_byte(tx_byte), .tx_done(tx_done)
    );

    int checks = 0, errors = 0;
    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // behavioural reference model; ph: 0 reset-low 1 reset-wait 2 load 3 run 4 hold 5 idle
    logic [8:0] script_tbl [6] = '{9'h100, 9'h001, 9'h006, 9'h00E, 9'h014, 9'h020};
    int ph = 0, n = 0, idx = 0;
    bit scr = 1'b1;
    logic [8:0] ureq = '0;
    logic [8:0] log_q[$];
    logic [8:0] user_q[$] = '{9'h141, 9'h001, 9'h080, 9'h15A, 9'h00C};

    function automatic logic [8:0] cur();
        return scr ? script_tbl[idx] : ureq;
    endfunction
    function automatic int hold_of(input logic [8:0] b);
        if (b[8]) return E_DATA;
        if (b[7:0] == 8'h01) return E_CLEAR;
        return E_CMD;
    endfunction

    task automatic step(input bit d, input bit v, input logic [8:0] vb);
        case (ph)
            0: if (n == E_RLOW - 1) begin ph = 1; n = 0; end else n++;
            1: if (n == E_RWAIT - 1) begin ph = 2; n = 0; idx = 0; scr = 1; end else n++;
            2: if (n == LOADC - 1) begin ph = 3; n = 0; end else n++;
            3: if (d) begin ph = 4; n = 0; end
            4: if (n == hold_of(cur()) - 1) begin
                   n = 0;
                   if (scr && idx < 5) begin idx++; ph = 2; end
                   else begin scr = 0; ph = 5; end
               end else n++;
            default: if (v) begin ureq = vb; ph = 2; n = 0; end
        endcase
    endtask

    int rcnt = 0, run_cnt = 0, nxfer = 0, idle_cnt = 0, cyc = 0;
    int quiet = 0, load_len = 0;
    bit after_run = 0;
    logic [8:0] last_sent = '0;
    bit done_flag = 0;

    task automatic finish_up();
        chk("R2 R6 R9 transfer count", log_q.size(), 11);
        if (log_q.size() >= 6) begin
            chk("R2 dummy data write", log_q[0], 9'h100);
            chk("R2 clear command", log_q[1], 9'h001);
            for (int i = 2; i < 6; i++) chk("R6 script order", log_q[i], script_tbl[i]);
        end
        if (log_q.size() == 11)
            for (int i = 0; i < 5; i++) chk("R3 user byte and rs", log_q[6+i],
                (i == 0) ? 9'h141 : (i == 1) ? 9'h001 : (i == 2) ? 9'h080 : (i == 3) ? 9'h15A : 9'h00C);
        foreach (log_q[i]) if (log_q[i][7:0] == 8'hEE) chk("R9 busy request ignored", log_q[i], 9'h000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(negedge clk) begin
        if (done_flag) begin
        end else if (!rst_n) begin
            chk("R1 reset line low in reset", lcd_rst_n, 0);
            chk("R9 no ready in reset", req_ready, 0);
            chk("R7 no load in reset", tx_load | tx_run, 0);
            rcnt++;
            if (rcnt == 4) begin
                rst_n = 1'b1;
                step(1'b0, 1'b0, 9'h0);
            end
        end else begin
            cyc++;
            // compare against model
            chk("R1 reset line", lcd_rst_n, ph != 0);
            chk("R7 load", tx_load, ph == 2);
            chk("R8 run", tx_run, ph == 3);
            chk("R9 ready", req_ready, ph == 5);
            if (ph == 2 || ph == 3) chk("R3 byte and rs", {tx_rs, tx_byte}, cur());
            if (ph == 2 && n == 0) begin log_q.push_back({tx_rs, tx_byte}); nxfer++; end
            // hold-off and load-length observer on the ports
            if (tx_load) load_len++;
            else if (load_len != 0) begin chk("R7 load length", load_len, LOADC); load_len = 0; end
            if (tx_run) begin after_run = 1; quiet = 0; last_sent = {tx_rs, tx_byte}; end
            else if (after_run && (tx_load || req_ready)) begin
                chk(last_sent[8] ? "R5 data hold-off" :
                    (last_sent[7:0] == 8'h01) ? "R4 clear hold-off" : "R5 command hold-off",
                    quiet, hold_of(last_sent));
                after_run = 0;
            end else if (after_run) quiet++;
            // transmitter model
            if (ph == 3) begin run_cnt++; tx_done = (run_cnt == 1 + (nxfer % 3)); end
            else begin run_cnt = 0; tx_done = 1'b0; end
            // user stimulus
            if (ph == 5) idle_cnt++; else idle_cnt = 0;
            if (ph == 5 && idle_cnt >= 3 && user_q.size() != 0) begin
                ureq = user_q.pop_front();
                req_valid = 1'b1; req_is_data = ureq[8]; req_byte = ureq[7:0];
            end else if (!scr && ph != 5) begin
                req_valid = 1'b1; req_is_data = 1'b1; req_byte = 8'hEE;
            end else begin
                req_valid = 1'b0; req_byte = 8'h00; req_is_data = 1'b0;
            end
            step(tx_done, req_valid, {req_is_data, req_byte});
            if (user_q.size() == 0 && ph == 5 && idle_cnt > 5) begin
                done_flag = 1; finish_up();
            end else if (cyc > 20000) begin
                done_flag = 1;
                errors++; checks++;
                $display("FAIL watchdog actual %0d expected %0d", cyc, 20000);
                finish_up();
            end
        end
    end
endmodule